// File: doc/BRIEF.md
# DSP Address Generation Unit

This block computes data-memory addresses for a signal-processing datapath so that the main arithmetic unit never spends cycles on pointer arithmetic. It keeps one address pointer plus a small set of configuration values: a step, the start and length of a circular buffer, and the log2 size of an FFT block. Whenever an access is accepted, the address for that access is the value on the output during that cycle. The pointer or the reorder counter then moves on at the clock edge that accepts the access, in the style of register-indirect addressing with post-increment.

Three update modes are supported. Linear mode adds the step. Modulo mode adds the step and folds the result back into the circular buffer. Bit-reversed mode walks an FFT data set in reversed-index order. In bit-reversed mode a plain binary counter is incremented and its low bits are shown mirrored, so no reversed carry chain is needed. Several instances can sit side by side so that several operands are addressed in the same cycle.

A pointer load has priority over an access. While a pointer load is present, the access strobe is not accepted.

Top module: `dsp_agu`

## Requirements
- R1: After reset the pointer is 0, the step is 1, the buffer start and length are 0, the FFT size is 3 bits (8 points) and the reorder counter is 0. `acc_ready` is high and `acc_addr` is 0.
- R2: The mode codes are 2'b00 linear, 2'b01 modulo, 2'b10 bit-reversed and 2'b11 hold. In linear mode `acc_addr` equals the pointer, and an accepted access sets the pointer to pointer+step modulo 2^ADDR_W on the next edge.
- R3: In modulo mode `acc_addr` equals the pointer. An accepted access computes s = pointer+step at ADDR_W+1 bits. If s is at least start+length (also at ADDR_W+1 bits), the next pointer is s-length; otherwise it is s.
- R4: In bit-reversed mode with size n, `acc_addr` takes the buffer start with its low n bits cleared, ORed with the low n counter bits mirrored (bit i comes from counter bit n-1-i). An accepted access sets the counter to (counter+1) mod 2^n. With n=3 the offsets visited are 0,4,2,6,1,5,3,7.
- R5: A size load stores the 4-bit value clamped to the range 1..MAX_LOG2: a 0 becomes 1 and a value above MAX_LOG2 becomes MAX_LOG2. The same load clears the reorder counter.
- R6: While `ld_ptr` is high, `acc_ready` is low and no access is accepted. On the next edge the pointer takes `ptr_in` and the reorder counter is cleared.
- R7: In hold mode `acc_addr` equals the pointer, and an accepted access changes neither the pointer nor the counter.
- R8: A bit-reversed access leaves the pointer unchanged. A linear or modulo access leaves the reorder counter unchanged.
- R9: A step, start or length load takes effect from the next cycle. With no load and no accepted access, all state holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| acc_valid | input | 1 | Access request strobe |
| acc_mode | input | 2 | Update mode for this access (see R2) |
| acc_ready | output | 1 | Access can be accepted this cycle |
| acc_addr | output | ADDR_W | Address for the current access |
| ld_ptr | input | 1 | Load pointer |
| ptr_in | input | ADDR_W | Pointer load value |
| ld_step | input | 1 | Load step |
| step_in | input | ADDR_W | Step load value |
| ld_base | input | 1 | Load circular/FFT buffer start |
| base_in | input | ADDR_W | Buffer start load value |
| ld_len | input | 1 | Load circular buffer length |
| len_in | input | ADDR_W | Buffer length load value |
| ld_size | input | 1 | Load FFT log2 size |
| size_in | input | LOG_W | FFT log2 size load value |

## Verification
`acc_addr` and `acc_ready` depend combinationally on the current state and on the mode and load inputs, so they are due in the same cycle the inputs are driven. Every load and every accepted access shows its effect exactly one edge later. The bench drives inputs on the falling edge and compares the outputs 1 ns later against a model that still holds the state from before the edge. Only after the following rising edge does the bench advance the model with the same inputs. A directed bit-reversed walk, modulo boundary hits, size clamping, load/access collisions and hold mode come first, followed by a long seeded random mix.

// File: rtl/agu_pkg.sv
package agu_pkg;
  typedef enum logic [1:0] {
    AGU_LINEAR = 2'b00,
    AGU_MODULO = 2'b01,
    AGU_BITREV = 2'b10,
    AGU_HOLD   = 2'b11
  } agu_mode_e;
endpackage

// File: rtl/agu_cfg_regs.sv
module agu_cfg_regs #(
  parameter int ADDR_W   = 16,
  parameter int MAX_LOG2 = 10,
  parameter int LOG_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_step,
  input  logic [ADDR_W-1:0] step_in,
  input  logic              ld_base,
  input  logic [ADDR_W-1:0] base_in,
  input  logic              ld_len,
  input  logic [ADDR_W-1:0] len_in,
  input  logic              ld_size,
  input  logic [LOG_W-1:0]  size_in,
  output logic [ADDR_W-1:0] step_q,
  output logic [ADDR_W-1:0] base_q,
  output logic [ADDR_W-1:0] len_q,
  output logic [LOG_W-1:0]  size_q
);
  localparam logic [LOG_W-1:0] SIZE_MAX = LOG_W'(MAX_LOG2);
  localparam logic [LOG_W-1:0] SIZE_RST = LOG_W'(3);

  logic [ADDR_W-1:0] step_d, base_d, len_d;
  logic [LOG_W-1:0]  size_d, size_clamped;

  always_comb begin
    if (size_in == '0)           size_clamped = LOG_W'(1);
    else if (size_in > SIZE_MAX) size_clamped = SIZE_MAX;
    else                         size_clamped = size_in;
  end

  always_comb begin
    step_d = ld_step ? step_in      : step_q;
    base_d = ld_base ? base_in      : base_q;
    len_d  = ld_len  ? len_in       : len_q;
    size_d = ld_size ? size_clamped : size_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= ADDR_W'(1);
      base_q <= '0;
      len_q  <= '0;
      size_q <= SIZE_RST;
    end else begin
      step_q <= step_d;
      base_q <= base_d;
      len_q  <= len_d;
      size_q <= size_d;
    end
  end

  // R5: stored size always inside the legal range
  assert_size_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (size_q >= LOG_W'(1)) && (size_q <= SIZE_MAX));

  // R9: configuration holds with no load
  assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_step && !ld_base && !ld_len) |=> ($stable(step_q) && $stable(base_q) && $stable(len_q)));
endmodule

// File: rtl/agu_linmod.sv
module agu_linmod #(
  parameter int ADDR_W = 16
) (
  input  logic              modulo_en,
  input  logic [ADDR_W-1:0] ptr,
  input  logic [ADDR_W-1:0] step,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] len,
  output logic [ADDR_W-1:0] ptr_next
);
  localparam int EW = ADDR_W + 1;

  logic [EW-1:0] sum_w, end_w, fold_w;
  logic          wrap;

  always_comb begin
    sum_w  = {1'b0, ptr}  + {1'b0, step};
    end_w  = {1'b0, base} + {1'b0, len};
    fold_w = sum_w - {1'b0, len};
    wrap   = modulo_en && (sum_w >= end_w);
    ptr_next = wrap ? fold_w[ADDR_W-1:0] : sum_w[ADDR_W-1:0];
  end
endmodule

// File: rtl/agu_bitrev.sv
module agu_bitrev #(
  parameter int ADDR_W   = 16,
  parameter int MAX_LOG2 = 10,
  parameter int LOG_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              adv,
  input  logic [LOG_W-1:0]  size_q,
  input  logic [ADDR_W-1:0] base_q,
  output logic [ADDR_W-1:0] br_addr
);
  localparam logic [LOG_W-1:0] SIZE_MAX = LOG_W'(MAX_LOG2);
  localparam int               PAD_W    = ADDR_W - MAX_LOG2;

  logic [MAX_LOG2-1:0] cnt_q, cnt_d, cnt_mask, rev_full, rev_sh;
  logic [LOG_W-1:0]    shamt;
  logic [ADDR_W-1:0]   addr_mask;

  always_comb begin
    shamt     = SIZE_MAX - size_q;
    cnt_mask  = {MAX_LOG2{1'b1}} >> shamt;
    addr_mask = {{PAD_W{1'b0}}, cnt_mask};
  end

  for (genvar gi = 0; gi < MAX_LOG2; gi++) begin : g_mirror
    assign rev_full[gi] = cnt_q[MAX_LOG2-1-gi];
  end

  always_comb begin
    rev_sh  = rev_full >> shamt;
    br_addr = (base_q & ~addr_mask) | {{PAD_W{1'b0}}, rev_sh};
  end

  always_comb begin
    if (clr)      cnt_d = '0;
    else if (adv) cnt_d = (cnt_q + MAX_LOG2'(1)) & cnt_mask;
    else          cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R4: counter stays inside the active size
  assert_cnt_in_size_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q & ~cnt_mask) == '0);

  // R5 / R6: clear request empties the counter
  assert_cnt_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));

  // R8: counter untouched without advance or clear
  assert_cnt_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !adv) |=> $stable(cnt_q));
endmodule

// File: rtl/dsp_agu.sv
module dsp_agu #(
  parameter  int ADDR_W   = 16,
  parameter  int MAX_LOG2 = 10,
  localparam int LOG_W    = $clog2(MAX_LOG2 + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic [1:0]        acc_mode,
  output logic              acc_ready,
  output logic [ADDR_W-1:0] acc_addr,
  input  logic              ld_ptr,
  input  logic [ADDR_W-1:0] ptr_in,
  input  logic              ld_step,
  input  logic [ADDR_W-1:0] step_in,
  input  logic              ld_base,
  input  logic [ADDR_W-1:0] base_in,
  input  logic              ld_len,
  input  logic [ADDR_W-1:0] len_in,
  input  logic              ld_size,
  input  logic [LOG_W-1:0]  size_in
);
  import agu_pkg::*;

  localparam int EW = ADDR_W + 1;

  // reset: asynchronous assert, synchronous release
  logic rst_s0, rst_ns;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s0 <= 1'b0;
      rst_ns <= 1'b0;
    end else begin
      rst_s0 <= 1'b1;
      rst_ns <= rst_s0;
    end
  end

  agu_mode_e         mode;
  logic              accept, ptr_en, br_adv, br_clr;
  logic [ADDR_W-1:0] ptr_q, ptr_d, ptr_step;
  logic [ADDR_W-1:0] step_q, base_q, len_q, br_addr;
  logic [LOG_W-1:0]  size_q;

  agu_cfg_regs #(.ADDR_W(ADDR_W), .MAX_LOG2(MAX_LOG2), .LOG_W(LOG_W)) u_cfg (
    .clk(clk), .rst_n(rst_ns),
    .ld_step(ld_step), .step_in(step_in),
    .ld_base(ld_base), .base_in(base_in),
    .ld_len(ld_len),   .len_in(len_in),
    .ld_size(ld_size), .size_in(size_in),
    .step_q(step_q), .base_q(base_q), .len_q(len_q), .size_q(size_q)
  );

  agu_linmod #(.ADDR_W(ADDR_W)) u_linmod (
    .modulo_en(mode == AGU_MODULO),
    .ptr(ptr_q), .step(step_q), .base(base_q), .len(len_q),
    .ptr_next(ptr_step)
  );

  agu_bitrev #(.ADDR_W(ADDR_W), .MAX_LOG2(MAX_LOG2), .LOG_W(LOG_W)) u_bitrev (
    .clk(clk), .rst_n(rst_ns),
    .clr(br_clr), .adv(br_adv),
    .size_q(size_q), .base_q(base_q),
    .br_addr(br_addr)
  );

  always_comb begin
    mode      = agu_mode_e'(acc_mode);
    acc_ready = !ld_ptr;
    accept    = acc_valid && acc_ready;
    ptr_en    = accept && ((mode == AGU_LINEAR) || (mode == AGU_MODULO));
    br_adv    = accept && (mode == AGU_BITREV);
    br_clr    = ld_ptr || ld_size;
    acc_addr  = (mode == AGU_BITREV) ? br_addr : ptr_q;
  end

  always_comb begin
    if (ld_ptr)      ptr_d = ptr_in;
    else if (ptr_en) ptr_d = ptr_step;
    else             ptr_d = ptr_q;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) ptr_q <= '0;
    else         ptr_q <= ptr_d;
  end

  // checker support: pointer inside a well-formed circular buffer
  logic [EW-1:0] buf_end;
  logic          in_buf, buf_ok;
  always_comb begin
    buf_end = {1'b0, base_q} + {1'b0, len_q};
    in_buf  = ({1'b0, ptr_q} >= {1'b0, base_q}) && ({1'b0, ptr_q} < buf_end);
    buf_ok  = (len_q != '0) && (step_q <= len_q) && (buf_end <= {1'b1, {ADDR_W{1'b0}}});
  end

  // R3: a modulo access from inside the buffer lands inside the buffer
  assert_mod_in_buffer_R3: assert property (@(posedge clk) disable iff (!rst_ns)
    (accept && mode == AGU_MODULO && !ld_base && !ld_len && in_buf && buf_ok) |=> in_buf);

  // R6: pointer load wins
  assert_ptr_load_R6: assert property (@(posedge clk) disable iff (!rst_ns)
    ld_ptr |=> (ptr_q == $past(ptr_in)));

  // R7: hold mode freezes the pointer
  assert_hold_mode_R7: assert property (@(posedge clk) disable iff (!rst_ns)
    (acc_valid && mode == AGU_HOLD && !ld_ptr) |=> $stable(ptr_q));

  // R8: bit-reversed access leaves pointer alone
  assert_bitrev_ptr_R8: assert property (@(posedge clk) disable iff (!rst_ns)
    (acc_valid && mode == AGU_BITREV && !ld_ptr) |=> $stable(ptr_q));

  // R9: idle pointer holds
  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_ns)
    (!acc_valid && !ld_ptr) |=> $stable(ptr_q));
endmodule

// File: tb/dsp_agu_bench.sv
module dsp_agu_bench;
  localparam int AW = 16;
  localparam int ML = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          acc_valid = 1'b0;
  logic [1:0]    acc_mode = 2'b00;
  logic          acc_ready;
  logic [AW-1:0] acc_addr;
  logic          ld_ptr = 1'b0, ld_step = 1'b0, ld_base = 1'b0, ld_len = 1'b0, ld_size = 1'b0;
  logic [AW-1:0] ptr_in = '0, step_in = '0, base_in = '0, len_in = '0;
  logic [3:0]    size_in = '0;

  int n_tests = 0;
  int n_fail  = 0;

  // model state
  logic [AW-1:0] m_ptr, m_step, m_base, m_len;
  int            m_size, m_cnt;

  always #4 clk = ~clk;

  dsp_agu #(.ADDR_W(AW), .MAX_LOG2(ML)) u_dsp_agu (
    .clk(clk), .rst_n(rst_n),
    .acc_valid(acc_valid), .acc_mode(acc_mode),
    .acc_ready(acc_ready), .acc_addr(acc_addr),
    .ld_ptr(ld_ptr), .ptr_in(ptr_in),
    .ld_step(ld_step), .step_in(step_in),
    .ld_base(ld_base), .base_in(base_in),
    .ld_len(ld_len), .len_in(len_in),
    .ld_size(ld_size), .size_in(size_in)
  );

  function automatic int f_rev(int c, int n);
    int r = 0;
    for (int i = 0; i < n; i++) if (((c >> (n - 1 - i)) & 1) != 0) r |= (1 << i);
    return r;
  endfunction

  function automatic logic [AW-1:0] f_addr(logic [1:0] md);
    logic [AW-1:0] mask;
    mask = AW'((1 << m_size) - 1);
    if (md == 2'b10) return (m_base & ~mask) | AW'(f_rev(m_cnt, m_size));
    return m_ptr;
  endfunction

  function automatic logic [AW-1:0] f_mod(logic [AW-1:0] p, logic [AW-1:0] s,
                                          logic [AW-1:0] b, logic [AW-1:0] l);
    logic [AW:0] sum, lim;
    sum = {1'b0, p} + {1'b0, s};
    lim = {1'b0, b} + {1'b0, l};
    if (sum >= lim) sum = sum - {1'b0, l};
    return sum[AW-1:0];
  endfunction

  function automatic int f_clamp(logic [3:0] v);
    if (v == 0) return 1;
    if (int'(v) > ML) return ML;
    return int'(v);
  endfunction

  task automatic check(string req, logic [AW-1:0] act, logic [AW-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one cycle: drive at falling edge, compare, advance model after rising edge
  task automatic cyc(input logic v, input logic [1:0] md,
                     input logic lp, input logic [AW-1:0] pv,
                     input logic ls, input logic [AW-1:0] sv,
                     input logic lb, input logic [AW-1:0] bv,
                     input logic ll, input logic [AW-1:0] lv,
                     input logic lz, input logic [3:0] zv,
                     input string req);
    acc_valid = v; acc_mode = md;
    ld_ptr = lp; ptr_in = pv; ld_step = ls; step_in = sv;
    ld_base = lb; base_in = bv; ld_len = ll; len_in = lv;
    ld_size = lz; size_in = zv;
    #1;
    check(req, acc_addr, f_addr(md));
    check(req, AW'(acc_ready), AW'(!lp));
    @(posedge clk);
    if (lp) begin
      m_ptr = pv; m_cnt = 0;
    end else if (v) begin
      case (md)
        2'b00: m_ptr = m_ptr + m_step;
        2'b01: m_ptr = f_mod(m_ptr, m_step, m_base, m_len);
        2'b10: m_cnt = (m_cnt + 1) & ((1 << m_size) - 1);
        default: ;
      endcase
    end
    if (ls) m_step = sv;
    if (lb) m_base = bv;
    if (ll) m_len = lv;
    if (lz) begin
      m_size = f_clamp(zv); m_cnt = 0;
    end
    @(negedge clk);
  endtask

  task automatic idle(input logic [1:0] md, input string req);
    cyc(1'b0, md, 1'b0, '0, 1'b0, '0, 1'b0, '0, 1'b0, '0, 1'b0, '0, req);
  endtask
  task automatic acc(input logic [1:0] md, input string req);
    cyc(1'b1, md, 1'b0, '0, 1'b0, '0, 1'b0, '0, 1'b0, '0, 1'b0, '0, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int unsigned seed;
    int exp8 [8] = '{0, 4, 2, 6, 1, 5, 3, 7};
    m_ptr = '0; m_step = AW'(1); m_base = '0; m_len = '0; m_size = 3; m_cnt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    idle(2'b00, "R1");
    idle(2'b10, "R1");
    acc(2'b00, "R1");                       // step of 1 after reset
    check("R1", acc_addr, AW'(1));

    // R9: config loads then idle hold
    cyc(1'b0, 2'b00, 1'b0, '0, 1'b1, AW'(3), 1'b1, AW'(16'h1200), 1'b1, AW'(10), 1'b0, '0, "R9");
    idle(2'b01, "R9");
    idle(2'b00, "R9");

    // R4: 8-point bit-reversed walk
    cyc(1'b0, 2'b10, 1'b0, '0, 1'b0, '0, 1'b0, '0, 1'b0, '0, 1'b1, 4'd3, "R5");
    for (int k = 0; k < 8; k++) begin
      #0;
      check("R4", acc_addr, AW'(16'h1200) | AW'(exp8[k]));
      acc(2'b10, "R4");
    end
    check("R4", acc_addr, AW'(16'h1200));   // wraps to 0
    idle(2'b00, "R8");                       // pointer unmoved by bitrev

    // R5: size clamping
    cyc(1'b0, 2'b10, 1'b0, '0, 1'b0, '0, 1'b0, '0, 1'b0, '0, 1'b1, 4'd0, "R5");
    acc(2'b10, "R5");
    acc(2'b10, "R5");
    cyc(1'b0, 2'b10, 1'b0, '0, 1'b0, '0, 1'b0, '0, 1'b0, '0, 1'b1, 4'd15, "R5");
    for (int k = 0; k < 5; k++) acc(2'b10, "R5");

    // R3: modulo exact boundary hit wraps to start
    cyc(1'b0, 2'b01, 1'b1, AW'(16'h1207), 1'b1, AW'(3), 1'b0, '0, 1'b0, '0, 1'b0, '0, "R6");
    acc(2'b01, "R3");
    check("R3", acc_addr, AW'(16'h1200));   // 0x1207+3 == end, folds to start
    acc(2'b01, "R3");
    acc(2'b01, "R3");
    acc(2'b01, "R3");

    // R8: linear access leaves bitrev counter alone
    cyc(1'b0, 2'b10, 1'b0, '0, 1'b0, '0, 1'b0, '0, 1'b0, '0, 1'b1, 4'd3, "R5");
    acc(2'b10, "R8");
    acc(2'b00, "R8");
    acc(2'b00, "R2");
    idle(2'b10, "R8");

    // R6: pointer load collides with access
    cyc(1'b1, 2'b00, 1'b1, AW'(16'h00F0), 1'b0, '0, 1'b0, '0, 1'b0, '0, 1'b0, '0, "R6");
    idle(2'b00, "R6");
    check("R6", acc_addr, AW'(16'h00F0));
    idle(2'b10, "R6");                       // counter cleared

    // R7: hold mode
    acc(2'b11, "R7");
    acc(2'b11, "R7");
    check("R7", acc_addr, AW'(16'h00F0));

    // R2: linear wrap at top of space
    cyc(1'b0, 2'b00, 1'b1, AW'(16'hFFFE), 1'b1, AW'(5), 1'b0, '0, 1'b0, '0, 1'b0, '0, "R2");
    acc(2'b00, "R2");
    check("R2", acc_addr, AW'(16'h0003));

    // random mix
    seed = 32'd1234;
    void'($urandom(seed));
    for (int k = 0; k < 4000; k++) begin
      logic          v, lp, ls, lb, ll, lz;
      logic [1:0]    md;
      logic [AW-1:0] lv, sv, bv, pv;
      int            r;
      r  = int'($urandom);
      v  = (r & 3) != 0;
      md = 2'(r >> 2);
      lp = ((r >> 4) & 15) == 0;
      ls = ((r >> 8) & 15) == 0;
      lb = ((r >> 12) & 31) == 0;
      ll = ((r >> 17) & 31) == 0;
      lz = ((r >> 22) & 31) == 0;
      lv = AW'(($urandom % 200) + 1);
      sv = AW'($urandom % (int'(m_len) + 1));
      bv = AW'($urandom % 60000);
      pv = (m_len != 0) ? AW'(int'(m_base) + int'($urandom % int'(m_len))) : AW'($urandom);
      cyc(v, md, lp, pv, ls, sv, lb, bv, ll, lv, lz, 4'($urandom), "R2");
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule